// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire serial memory protocol engine. It gathers the data bytes of one write transaction into a small page buffer. When the transaction closes with a stop, it transfers the received bytes to the memory array. The engine hands over each byte with a one-cycle strobe, the byte and its address, and it signals a stop with another one-cycle strobe.

The first data byte of a transaction fixes the page row (the upper address bits) and the starting slot (the low address bits). Each later byte goes to the next slot of the same page. Past the last slot the pointer wraps to slot 0 and overwrites what is there. One valid flag per slot makes sure that only the slots actually received are written to the array.

After a committing stop the block is busy. It first scans the page and issues one array write per cycle. It then waits for a set number of prescaled tick pulses, which stands in for the self-timed programming cycle. The protocol engine uses the busy flag to withhold device-address acknowledges, so a master can poll with acknowledges. A high write-protect level at the stop discards the page, and no busy period follows.

Top module: `page_write_commit`

## Requirements
- R1: The first byte strobe after reset or after a stop sets the page row from `byte_addr_i[ADDR_W-1:PAGE_W]` and the slot from `byte_addr_i[PAGE_W-1:0]`. Each later byte goes to the previous slot plus one, modulo 2^PAGE_W, and its address input is ignored.
- R2: When more than 2^PAGE_W bytes arrive, the slot pointer wraps inside the page. The array receives the last byte written to each slot.
- R3: At commit only the slots that received a byte are written. Every other array location keeps its content, and the number of array writes equals the number of distinct slots received.
- R4: A stop with at least one received byte and `wp_i` low raises `busy_o` in the next cycle. During the first 2^PAGE_W busy cycles the valid slots are written in ascending slot order, at most one per cycle, with `mem_addr_o` = {row, slot}.
- R5: After the scan, `busy_o` stays high until CYCLE_TICKS pulses of `tick_i` have been seen, and it falls in the cycle after the last one. Ticks that arrive during the scan do not count.
- R6: A stop with `wp_i` high produces no array write, leaves `busy_o` low and empties the buffer.
- R7: A stop with no received bytes produces no array write and leaves `busy_o` low.
- R8: While `busy_o` is high, byte strobes and stop strobes are ignored. This includes a strobe that arrives in the same cycle as the final tick.
- R9: After reset `busy_o` and `mem_we_o` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | One-cycle strobe for a received data byte |
| byte_addr_i | input | ADDR_W | Byte address (used only for the first byte) |
| byte_data_i | input | DATA_W | Byte value |
| stop_i | input | 1 | One-cycle strobe for a stop condition |
| wp_i | input | 1 | Write-protect level, high protects the whole array |
| tick_i | input | 1 | Prescaled timer tick pulse |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | High during the commit scan and the programming wait |

## Verification
The end of the programming wait can coincide with a new request. The final tick pulse, the one that ends the busy period, can arrive in the same cycle as a byte strobe from the protocol engine. The bench drives a byte strobe together with that final tick, and it also sends stray bytes and stops earlier in the wait. It then issues a fresh stop. The stray bytes have been refused if this stop leaves `busy_o` low and produces no array write. A full sweep over every start slot, with 1 to 12 bytes, checks the wrap and the partial-page behaviour against a memory image computed in the bench.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } pwb_state_e;

  // a stop triggers programming only with data present and protection off
  function automatic logic take_commit(input logic any_vld, input logic wp);
    return any_vld & ~wp;
  endfunction
endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              first_i,
  input  logic [PAGE_W-1:0] start_slot_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [PAGE];
  logic [PAGE-1:0]   vld_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE_W-1:0] wr_slot;

  assign wr_slot = first_i ? start_slot_i : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (wr_i) begin
      vld_q[wr_slot] <= 1'b1;
      ptr_q          <= wr_slot + 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_i && !clr_i && wr_slot == PAGE_W'(i)) slot_q[i] <= din_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;

  // R1: a write after the first byte lands one slot after the previous one
  a_r1_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (ptr_q == $past(wr_slot) + 1'b1));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int TICKS = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic done_o
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign done_o = run_q && tick_i && (cnt_q == CW'(TICKS - 1));
  assign run_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the count moves only on a tick
  a_r5_count_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int DATA_W      = 8,
  parameter int CYCLE_TICKS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              tick_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              busy_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] LAST = PAGE_W'((1 << PAGE_W) - 1);

  pwb_state_e        st_q;
  logic [PAGE_W-1:0] idx_q;
  logic [ROW_W-1:0]  row_q;
  logic              open_q;

  // named internal events
  logic accept_ev, first_ev, commit_ev, drop_ev, scan_end_ev, tmr_done;
  logic rd_vld, any_vld, tmr_run;
  logic [DATA_W-1:0] rd_data;

  assign accept_ev   = byte_vld_i && (st_q == ST_IDLE) && !stop_i;
  assign first_ev    = accept_ev && !open_q;
  assign commit_ev   = (st_q == ST_IDLE) && stop_i && take_commit(any_vld, wp_i);
  assign drop_ev     = (st_q == ST_IDLE) && stop_i && !take_commit(any_vld, wp_i);
  assign scan_end_ev = (st_q == ST_SCAN) && (idx_q == LAST);

  pwb_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (accept_ev),
    .first_i      (first_ev),
    .start_slot_i (byte_addr_i[PAGE_W-1:0]),
    .din_i        (byte_data_i),
    .clr_i        (drop_ev || scan_end_ev),
    .rd_idx_i     (idx_q),
    .rd_data_o    (rd_data),
    .rd_vld_o     (rd_vld),
    .any_vld_o    (any_vld)
  );

  pwb_timer #(.TICKS(CYCLE_TICKS)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (scan_end_ev),
    .tick_i  (tick_i),
    .run_o   (tmr_run),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      row_q  <= '0;
      open_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (first_ev)  row_q  <= byte_addr_i[ADDR_W-1:PAGE_W];
          if (accept_ev) open_q <= 1'b1;
          if (stop_i)    open_q <= 1'b0;
          if (commit_ev) begin
            st_q  <= ST_SCAN;
            idx_q <= '0;
          end
        end
        ST_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (scan_end_ev) st_q <= ST_WAIT;
        end
        ST_WAIT: if (tmr_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign mem_we_o   = (st_q == ST_SCAN) && rd_vld;
  assign mem_addr_o = {row_q, idx_q};
  assign mem_data_o = rd_data;

  a_r4_we_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  a_r4_busy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !wp_i && any_vld) |=> busy_o);
  a_r4_row_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:PAGE_W]));
  a_r6_wp_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && wp_i) |=> !busy_o);
  a_r7_empty_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !any_vld) |=> !busy_o);
  a_r8_wait_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> (!any_vld && tmr_run));
endmodule

// File: tb/page_write_commit_tb.sv
module page_write_commit_tb;
  localparam int ADDR_W = 8;
  localparam int PAGE_W = 3;
  localparam int DATA_W = 8;
  localparam int TICKS  = 4;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0, stop = 1'b0, wp = 1'b0, tick = 1'b0;
  logic [ADDR_W-1:0] byte_addr = '0;
  logic [DATA_W-1:0] byte_data = '0;
  logic mem_we, busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;

  int checks = 0, errors = 0;
  int wcnt = 0, order_err = 0;
  int last_addr = -1;
  bit finished = 0;
  logic [DATA_W-1:0] arr [DEPTH];
  logic [DATA_W-1:0] ref_arr [DEPTH];

  always #10 clk = ~clk;

  page_write_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                      .CYCLE_TICKS(TICKS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(byte_vld), .byte_addr_i(byte_addr),
    .byte_data_i(byte_data), .stop_i(stop), .wp_i(wp), .tick_i(tick),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .busy_o(busy));

  // array model fed from the write port
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      arr[mem_addr] <= mem_data;
      if (int'(mem_addr) <= last_addr) order_err++;
      last_addr = int'(mem_addr);
      wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int t, input int j);
    return DATA_W'(t * 37 + j * 11 + 5);
  endfunction

  task automatic send_bytes(input int row, input int off, input int n, input int t);
    for (int j = 0; j < n; j++) begin
      byte_vld  = 1'b1;
      byte_addr = (j == 0) ? ADDR_W'(row * PAGE + off) : ~ADDR_W'(row * PAGE + off + j);
      byte_data = pat(t, j);
      @(negedge clk);
    end
    byte_vld = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      arr[a] = '0;
      ref_arr[a] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(mem_we == 1'b0, "R9 we", mem_we, 0);
    pulse_stop();
    chk(busy == 1'b0 && wcnt == 0, "R9 empty buffer", wcnt, 0);

    // sweep all start slots and 1..12 bytes (R1 R2 R3 R4 R5)
    for (int off = 0; off < PAGE; off++) begin
      for (int n = 1; n <= 12; n++) begin
        int t, row, exp_w, bad;
        t = off * 12 + n - 1;
        row = t % (DEPTH / PAGE);
        for (int j = 0; j < n; j++) ref_arr[row * PAGE + (off + j) % PAGE] = pat(t, j);
        exp_w = (n < PAGE) ? n : PAGE;
        wcnt = 0; last_addr = -1; order_err = 0;
        send_bytes(row, off, n, t);
        pulse_stop();
        chk(busy == 1'b1, "R4 busy after stop", busy, 1);
        tick = 1'b1;                      // ticks during the scan do not count (R5)
        repeat (PAGE) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        chk(wcnt == exp_w, "R3 write count", wcnt, exp_w);
        chk(order_err == 0, "R4 ascending order", order_err, 0);
        bad = 0;
        for (int a = 0; a < DEPTH; a++) if (arr[a] !== ref_arr[a]) bad++;
        chk(bad == 0, "R1 R2 R3 array image", bad, 0);
        for (int k = 0; k < TICKS - 1; k++) pulse_tick();
        chk(busy == 1'b1, "R5 busy before last tick", busy, 1);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(busy == 1'b0, "R5 busy after last tick", busy, 0);
      end
    end

    // R6 write protect: no writes, no busy, buffer discarded
    wcnt = 0;
    send_bytes(3, 2, 5, 500);
    wp = 1'b1;
    pulse_stop();
    wp = 1'b0;
    chk(busy == 1'b0, "R6 no busy", busy, 1'b0);
    repeat (PAGE + 2) @(negedge clk);
    chk(wcnt == 0, "R6 no write", wcnt, 0);
    pulse_stop();
    repeat (PAGE + 2) @(negedge clk);
    chk(wcnt == 0 && busy == 1'b0, "R6 buffer discarded", wcnt, 0);

    // R7 stop without bytes
    pulse_stop();
    chk(busy == 1'b0, "R7 no busy", busy, 0);

    // R8 strobes while busy, one on the final tick
    wcnt = 0;
    send_bytes(9, 0, 1, 600);
    ref_arr[9 * PAGE] = pat(600, 0);
    pulse_stop();
    repeat (PAGE + 1) @(negedge clk);
    send_bytes(12, 4, 3, 700);
    pulse_stop();
    for (int k = 0; k < TICKS - 1; k++) pulse_tick();
    tick = 1'b1; byte_vld = 1'b1; byte_addr = ADDR_W'(20 * PAGE); byte_data = 8'hA5;
    @(negedge clk);
    tick = 1'b0; byte_vld = 1'b0;
    chk(busy == 1'b0, "R8 idle after wait", busy, 0);
    pulse_stop();
    chk(busy == 1'b0, "R8 refused strobes", busy, 0);
    repeat (PAGE + 2) @(negedge clk);
    chk(wcnt == 1, "R8 write count", wcnt, 1);
    chk(arr[20 * PAGE] === ref_arr[20 * PAGE], "R8 final tick byte", arr[20 * PAGE], ref_arr[20 * PAGE]);
    chk(arr[12 * PAGE + 4] === ref_arr[12 * PAGE + 4], "R8 busy byte", arr[12 * PAGE + 4], ref_arr[12 * PAGE + 4]);
    finish_run();
  end
endmodule